// File: doc/BRIEF.md
# Serial Flash Status and Busy Controller

This block sits behind the serial command port of a flash device and owns two pieces of state: the status byte that a host can poll, and the self-timed busy period that follows a page-program command. Serial traffic reaches it as a chip-select level, a one-cycle strobe for each serial clock and the data bit that goes with that strobe, all in the system clock domain. Once a status-read opcode is complete, the block serialises the status byte MSB first, one bit for each strobe. It repeats the byte, with fresh contents on each pass, until chip select goes high again.

The block also watches the same stream for the four page-program opcodes. If chip select rises after a complete 32-bit program frame, it emits a one-cycle start pulse carrying the buffer number, the page number and an erase flag, for the engine that moves the data. At that point it enters a busy period whose length comes from one of two cycle-count parameters, selected by whether the opcode includes a built-in erase. Ready is low for the whole period, and a compare-result input keeps the mismatch bit of the status byte up to date.

Top module: `stat_busy_ctrl`

## Requirements
- R1: A frame whose first eight bits (MSB first) are 57h or D7h is a status read. From the strobe that completes the opcode onward, `spi_sdo` presents status bit 7, and each further strobe advances to the next lower bit.
- R2: After bit 0 has been presented, the next strobe restarts at bit 7 with the status sampled at that moment, so a change from busy to ready appears on the following pass.
- R3: Status bit 7 is 1 when idle and 0 when busy. Bit 6 is the compare bit. Bits 5 down to 2 are fixed at 1,0,0,1 and bits 1 and 0 are 0. Idle with compare 0 therefore gives A4h.
- R4: The compare bit resets to 0. In any cycle with `cmp_valid` high it takes the value of `cmp_mismatch` (1 means mismatch).
- R5: Opcodes 83h, 86h, 88h and 89h are program commands. The frame is 32 bits long: the opcode, 3 reserved bits, a 12-bit page number (MSB first) and 9 don't-care bits. A rising edge of `spi_cs_n` after at least 32 strobes starts the operation. Strobes beyond 32 are ignored.
- R6: `prog_start` is high for exactly one cycle, in the cycle after the clock edge that samples the chip-select rise. In that cycle `prog_page` holds the page number, `prog_buf` is 0 for 83h/88h and 1 for 86h/89h, and `prog_erase` is 1 for 83h/86h and 0 for 88h/89h.
- R7: `busy` goes high together with `prog_start` and stays high for exactly ERASE_CYC cycles after an erase-plus-program command, or PROG_CYC cycles after a program-only command.
- R8: A program frame closed by chip select after fewer than 32 strobes is discarded: no start pulse and no busy period.
- R9: While `busy` is high, a new program command produces no start pulse and does not change the remaining busy time. Status reads are still served during that time and report bit 7 as 0.
- R10: A complete frame with any other opcode starts nothing. `spi_sdo` is 0 from the cycle after chip select is seen high until the next status read.
- R11: After reset, `busy`, `prog_start` and `spi_sdo` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_cs_n | input | 1 | Chip select, active low, sampled on clk |
| spi_bit_stb | input | 1 | One-cycle strobe per serial clock |
| spi_sdi | input | 1 | Serial data bit, valid with the strobe |
| spi_sdo | output | 1 | Serial status bit |
| cmp_valid | input | 1 | Compare result is valid this cycle |
| cmp_mismatch | input | 1 | Compare result: 1 means mismatch |
| busy | output | 1 | Self-timed operation in progress |
| prog_start | output | 1 | One-cycle start of a program operation |
| prog_buf | output | 1 | Source buffer: 0 first, 1 second |
| prog_erase | output | 1 | Operation includes a built-in page erase |
| prog_page | output | 12 | Target page number |

## Verification
The bench builds the block with ERASE_CYC = 120 and PROG_CYC = 80. These lengths are long enough for a whole status pass, or a complete second program frame, to fit inside one busy period. That makes it possible to observe ready dropping and then recovering within a single chip-select window, and to show that a command arriving mid-busy is ignored. The two counts also differ, so the busy lengths that are measured distinguish the erase and program-only variants.

// File: rtl/stat_busy_pkg.sv
package stat_busy_pkg;
    localparam int OP_BITS    = 8;
    localparam int RSV_BITS   = 3;
    localparam int PAGE_BITS  = 12;
    localparam int TAIL_BITS  = 9;
    localparam int FRAME_BITS = OP_BITS + RSV_BITS + PAGE_BITS + TAIL_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int PAGE_LSB   = TAIL_BITS;
    localparam logic [3:0] DENSITY_CODE = 4'b1001;

    typedef struct packed {
        logic                 buf_sel;
        logic                 erase;
        logic [PAGE_BITS-1:0] page;
    } prog_cmd_t;

    function automatic logic is_status_op(input logic [7:0] op);
        return (op == 8'h57) || (op == 8'hD7);
    endfunction

    function automatic logic is_prog_op(input logic [7:0] op);
        return (op == 8'h83) || (op == 8'h86) || (op == 8'h88) || (op == 8'h89);
    endfunction

    function automatic prog_cmd_t decode_prog(input logic [FRAME_BITS-1:0] w);
        prog_cmd_t c;
        logic [7:0] op;
        op        = w[FRAME_BITS-1 -: OP_BITS];
        c.buf_sel = (op == 8'h86) || (op == 8'h89);
        c.erase   = (op == 8'h83) || (op == 8'h86);
        c.page    = w[PAGE_LSB +: PAGE_BITS];
        return c;
    endfunction
endpackage

// File: rtl/sb_frame.sv
module sb_frame
    import stat_busy_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  bit_stb,
    input  logic                  sdi,
    output logic                  op_done,
    output logic [OP_BITS-1:0]    op_now,
    output logic                  frame_end,
    output logic                  frame_full,
    output logic [FRAME_BITS-1:0] frame_word
);
    typedef struct packed {
        logic                  cs;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] sh;
    } fr_state_t;

    fr_state_t st_q, st_d;
    logic      take;

    always_comb begin
        take       = !cs_n && bit_stb && (st_q.cnt < CNT_W'(FRAME_BITS));
        op_done    = take && (st_q.cnt == CNT_W'(OP_BITS - 1));
        op_now     = {st_q.sh[OP_BITS-2:0], sdi};
        frame_end  = cs_n && !st_q.cs;
        frame_full = (st_q.cnt == CNT_W'(FRAME_BITS));
        frame_word = st_q.sh;

        st_d    = st_q;
        st_d.cs = cs_n;
        if (cs_n) begin
            st_d.cnt = '0;
        end else if (take) begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.sh  = {st_q.sh[FRAME_BITS-2:0], sdi};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cs: 1'b1, cnt: '0, sh: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R5: the bit count never passes the frame length
    p_cnt_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(FRAME_BITS));
    // R8: a frame closed by chip select always restarts from zero
    p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (st_q.cnt == '0));
endmodule

// File: rtl/sb_timer.sv
module sb_timer #(
    parameter int ERASE_CYC = 2000,
    parameter int PROG_CYC  = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic erase,
    output logic busy
);
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tm_state_t;

    tm_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = erase ? CW'(ERASE_CYC) : CW'(PROG_CYC);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;

    // R7: a start while idle raises busy on the next edge
    p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !st_q.busy) |=> st_q.busy);
    // R7: busy only ends once the count has run down to one
    p_end_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> ($past(st_q.cnt) == CW'(1)));
    // R9: a start during busy never reloads the counter
    p_no_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != CW'(1)) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
endmodule

// File: rtl/sb_status_tx.sv
module sb_status_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       load,
    input  logic       bit_stb,
    input  logic [7:0] live,
    output logic       sdo
);
    typedef struct packed {
        logic       act;
        logic [2:0] pos;
        logic [7:0] sh;
    } tx_state_t;

    tx_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (cs_n) begin
            st_d = '0;
        end else if (load) begin
            st_d.act = 1'b1;
            st_d.pos = '0;
            st_d.sh  = live;
        end else if (st_q.act && bit_stb) begin
            if (st_q.pos == 3'd7) begin
                st_d.pos = '0;
                st_d.sh  = live;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
                st_d.sh  = {st_q.sh[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo = st_q.act & st_q.sh[7];

    // R2: every pass restarts on bit 7 with a fresh sample
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && st_q.act && bit_stb && st_q.pos == 3'd7) |=> (st_q.sh == $past(live)));
endmodule

// File: rtl/stat_busy_ctrl.sv
module stat_busy_ctrl
    import stat_busy_pkg::*;
#(
    parameter int ERASE_CYC = 2000,
    parameter int PROG_CYC  = 1500
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_cs_n,
    input  logic                 spi_bit_stb,
    input  logic                 spi_sdi,
    output logic                 spi_sdo,
    input  logic                 cmp_valid,
    input  logic                 cmp_mismatch,
    output logic                 busy,
    output logic                 prog_start,
    output logic                 prog_buf,
    output logic                 prog_erase,
    output logic [PAGE_BITS-1:0] prog_page
);
    typedef struct packed {
        logic      comp;
        logic      start;
        prog_cmd_t cmd;
    } top_state_t;

    top_state_t st_q, st_d;

    logic                  op_done, frame_end, frame_full, go, stat_load;
    logic [OP_BITS-1:0]    op_now;
    logic [FRAME_BITS-1:0] frame_word;
    logic [7:0]            live;

    sb_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (spi_cs_n),
        .bit_stb    (spi_bit_stb),
        .sdi        (spi_sdi),
        .op_done    (op_done),
        .op_now     (op_now),
        .frame_end  (frame_end),
        .frame_full (frame_full),
        .frame_word (frame_word)
    );

    always_comb begin
        live      = {~busy, st_q.comp, DENSITY_CODE, 2'b00};
        stat_load = op_done && is_status_op(op_now);
        go        = frame_end && frame_full && !busy
                    && is_prog_op(frame_word[FRAME_BITS-1 -: OP_BITS]);

        st_d       = st_q;
        st_d.start = go;
        if (cmp_valid) st_d.comp = cmp_mismatch;
        if (go)        st_d.cmd  = decode_prog(frame_word);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sb_timer #(
        .ERASE_CYC (ERASE_CYC),
        .PROG_CYC  (PROG_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (go),
        .erase (decode_prog(frame_word).erase),
        .busy  (busy)
    );

    sb_status_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (spi_cs_n),
        .load    (stat_load),
        .bit_stb (spi_bit_stb),
        .live    (live),
        .sdo     (spi_sdo)
    );

    assign prog_start = st_q.start;
    assign prog_buf   = st_q.cmd.buf_sel;
    assign prog_erase = st_q.cmd.erase;
    assign prog_page  = st_q.cmd.page;

    // R6: the start pulse lasts a single cycle
    p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start);
    // R7: the start pulse and the busy period begin together
    p_start_with_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> busy);
    // R9: no start is issued if busy was already high
    p_no_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !$past(busy));
    // R1: the first bit after a status opcode is the ready flag
    p_first_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stat_load |=> (spi_sdo == !$past(busy)));
    // R10: output is quiet once chip select is seen high
    p_sdo_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |=> !spi_sdo);
    // R4: compare bit follows a valid compare result
    p_comp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> (st_q.comp == $past(cmp_mismatch)));
endmodule

// File: tb/sim_stat_busy_ctrl.sv
`timescale 1ns/1ps
module sim_stat_busy_ctrl;
    localparam int EC = 120;
    localparam int PC = 80;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, stb = 1'b0, sdi = 1'b0, cmp_v = 1'b0, cmp_m = 1'b0;
    logic sdo, busy, pstart, pbuf, perase;
    logic [11:0] ppage;

    int n_run = 0, n_fail = 0;
    int starts = 0, busy_cyc = 0;
    logic cap_buf, cap_erase;
    logic [11:0] cap_page;
    bit done = 0;

    always #4 clk = ~clk;

    stat_busy_ctrl #(.ERASE_CYC(EC), .PROG_CYC(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_bit_stb(stb),
        .spi_sdi(sdi), .spi_sdo(sdo), .cmp_valid(cmp_v), .cmp_mismatch(cmp_m),
        .busy(busy), .prog_start(pstart), .prog_buf(pbuf),
        .prog_erase(perase), .prog_page(ppage));

    always @(negedge clk) begin
        if (rst_n) begin
            if (pstart) begin
                starts++;
                cap_buf = pbuf; cap_erase = perase; cap_page = ppage;
            end
            if (busy) busy_cyc++;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic strobe(input logic b);
        @(negedge clk); sdi = b; stb = 1'b1;
        @(negedge clk); stb = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] w, input int n);
        for (int i = 31; i > 31 - n; i--) strobe(w[i]);
    endtask

    task automatic cs_low();
        @(negedge clk); cs_n = 1'b0;
    endtask

    task automatic cs_high();
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_pass(input bit first, output logic [7:0] v);
        if (!first) strobe(1'b0);
        v[7] = sdo;
        for (int i = 6; i >= 0; i--) begin
            strobe(1'b0);
            v[i] = sdo;
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] frame(input logic [7:0] op, input logic [11:0] pg);
        return {op, 3'b000, pg, 9'h000};
    endfunction

    task automatic t_reset();
        check("R11 busy", busy, 0);
        check("R11 prog_start", pstart, 0);
        check("R11 sdo", sdo, 0);
    endtask

    task automatic t_status_idle(input logic [7:0] op);
        logic [7:0] v;
        cs_low();
        send_bits({op, 24'h0}, 8);
        read_pass(1, v);
        check("R1 R3 idle status first pass", v, 8'hA4);
        read_pass(0, v);
        check("R2 idle status second pass", v, 8'hA4);
        cs_high();
        check("R10 sdo quiet after cs high", sdo, 0);
    endtask

    task automatic t_compare();
        logic [7:0] v;
        @(negedge clk); cmp_v = 1'b1; cmp_m = 1'b1;
        @(negedge clk); cmp_v = 1'b0; cmp_m = 1'b0;
        cs_low();
        send_bits({8'h57, 24'h0}, 8);
        read_pass(1, v);
        check("R4 mismatch shows in bit 6", v, 8'hE4);
        cs_high();
        @(negedge clk); cmp_v = 1'b1; cmp_m = 1'b0;
        @(negedge clk); cmp_v = 1'b0;
        cs_low();
        send_bits({8'hD7, 24'h0}, 8);
        read_pass(1, v);
        check("R4 match clears bit 6", v, 8'hA4);
        cs_high();
    endtask

    task automatic t_program(input logic [7:0] op, input logic [11:0] pg,
                             input logic eb, input logic ee, input int len);
        starts = 0; busy_cyc = 0;
        cs_low();
        send_bits(frame(op, pg), 32);
        cs_high();
        check("R7 busy right after start", busy, 1);
        wait_idle();
        check("R5 one start per command", starts, 1);
        check("R6 page field", cap_page, pg);
        check("R6 buffer field", cap_buf, eb);
        check("R6 erase flag", cap_erase, ee);
        check("R7 busy length", busy_cyc, len);
    endtask

    task automatic t_extra_bits();
        starts = 0; busy_cyc = 0;
        cs_low();
        send_bits(frame(8'h89, 12'h5A5), 32);
        send_bits(32'hFFFF_FFFF, 6);
        cs_high();
        wait_idle();
        check("R5 extra bits ignored, start", starts, 1);
        check("R5 extra bits ignored, page", cap_page, 12'h5A5);
        check("R5 extra bits ignored, length", busy_cyc, PC);
    endtask

    task automatic t_truncated();
        starts = 0; busy_cyc = 0;
        cs_low();
        send_bits(frame(8'h83, 12'h123), 31);
        cs_high();
        wait_idle();
        check("R8 short frame no start", starts, 0);
        check("R8 short frame no busy", busy_cyc, 0);
    endtask

    task automatic t_other_op();
        starts = 0; busy_cyc = 0;
        cs_low();
        send_bits(frame(8'h52, 12'h321), 32);
        cs_high();
        wait_idle();
        check("R10 other opcode no start", starts, 0);
        check("R10 other opcode no busy", busy_cyc, 0);
        check("R10 sdo quiet", sdo, 0);
    endtask

    task automatic t_busy_status();
        logic [7:0] v;
        starts = 0; busy_cyc = 0;
        cs_low();
        send_bits(frame(8'h83, 12'h0F0), 32);
        cs_high();
        cs_low();
        send_bits({8'h57, 24'h0}, 8);
        read_pass(1, v);
        check("R9 status served while busy", v, 8'h24);
        while (busy) @(negedge clk);
        read_pass(0, v);
        check("R2 live ready on next pass", v, 8'hA4);
        cs_high();
        check("R7 busy length under status reads", busy_cyc, EC);
    endtask

    task automatic t_busy_ignore();
        starts = 0; busy_cyc = 0;
        cs_low();
        send_bits(frame(8'h83, 12'hABC), 32);
        cs_high();
        cs_low();
        send_bits(frame(8'h89, 12'h111), 32);
        cs_high();
        check("R9 still busy after second frame", busy, 1);
        wait_idle();
        check("R9 second command ignored", starts, 1);
        check("R9 page from first command", cap_page, 12'hABC);
        check("R9 busy length unchanged", busy_cyc, EC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status_idle(8'h57);
        t_status_idle(8'hD7);
        t_compare();
        t_program(8'h83, 12'hABC, 1'b0, 1'b1, EC);
        t_program(8'h86, 12'hFFF, 1'b1, 1'b1, EC);
        t_program(8'h88, 12'h000, 1'b0, 1'b0, PC);
        t_program(8'h89, 12'h801, 1'b1, 1'b0, PC);
        t_extra_bits();
        t_truncated();
        t_other_op();
        t_busy_status();
        t_busy_ignore();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule